// File: doc/BRIEF.md
# Mode-Controlled Numerically Controlled Oscillator with Holdover

This block is the oscillator core of a network-synchronization phase-locked loop. A wide phase accumulator advances on every clock by a frequency word, and the accumulator's carry-out becomes an output clock enable. The frequency word depends on a two-bit operating mode. In tracking mode the word is a nominal value plus a signed correction from the loop filter. In holdover mode the word is a value learned earlier, while the loop was tracking. In free-run mode the word is the nominal value alone, so the output runs at the rate set by the local master clock.

While the block is tracking, a holdover word follows the applied frequency word as an exponential running average. The average is updated once per frame strobe. When the reference is lost, the surrounding control logic selects holdover mode and the oscillator carries on at the learned average. A mode change only selects a different frequency word. The accumulator itself is never cleared, so the output phase does not jump at a switchover. The current accumulator value is also brought out as a phase word for downstream phase interpolation.

Top module: `sync_nco`

## Requirements
- R1: While reset is asserted, the phase output is 0 and the clock enable is 0. The holdover word resets to the nominal increment NOM_INC.
- R2: With mode 2'b00 (tracking), each clock adds NOM_INC plus the correction input to the phase, modulo 2^ACC_W.
- R3: With mode 2'b10 (free-run), each clock adds exactly NOM_INC to the phase, and the correction input has no effect.
- R4: Mode 2'b11 behaves exactly as free-run: the phase advances by NOM_INC, whatever the correction is.
- R5: With mode 2'b01 (holdover), each clock adds the stored holdover word to the phase, and the correction input has no effect.
- R6: When the frame strobe is high in a cycle with mode 2'b00, the holdover word becomes old + floor((inc − old) / 2^6), modulo 2^ACC_W. Here inc is that cycle's applied increment and the difference is a signed value.
- R7: The holdover word does not change in any cycle where the mode is not 2'b00, even when the frame strobe is high. It also does not change in a tracking cycle without a strobe.
- R8: The clock enable is high in the cycle after an addition that carried out of ACC_W bits, and is low otherwise. It updates in the same edge as the phase word that results from that addition.
- R9: A mode change never resets or steps the accumulator. The first phase value after a change equals the previous phase plus the increment of the new mode.
- R10: The correction is a CORR_W-bit two's-complement value and is sign-extended, so a negative correction lowers the tracking rate below nominal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 tracking, 01 holdover, 10 free-run, 11 free-run |
| corr_i | input | CORR_W | Signed frequency correction from the loop filter |
| frame_stb_i | input | 1 | Frame strobe that paces the holdover averaging |
| clk_en_o | output | 1 | Registered accumulator carry-out, used as the output clock enable |
| phase_o | output | ACC_W | Current accumulator phase |

## Verification
The bench builds the block with ACC_W = 32, CORR_W = 24, an averaging shift of 6 and NOM_INC = 32'h6A3D_70A4. This nominal word is about 0.41 of full scale, so the accumulator wraps every two or three clocks and the carry-out clock enable is checked many times per run. Full-range 24-bit corrections, both positive and negative, move the tracking rate far enough that the learned holdover word differs measurably from nominal within a few hundred cycles. Holdover then gives a phase slope distinct from free-run. Strobes given in holdover, free-run and the 2'b11 code are followed by holdover intervals whose phase slope shows that the learned word is unchanged.

// File: rtl/sync_nco_pkg.sv
package sync_nco_pkg;

    typedef enum logic [1:0] {
        MODE_TRACK    = 2'b00,
        MODE_HOLD     = 2'b01,
        MODE_FREE     = 2'b10,
        MODE_FREE_ALT = 2'b11
    } nco_mode_e;

    function automatic logic is_tracking(input logic [1:0] m);
        return m == MODE_TRACK;
    endfunction

endpackage

// File: rtl/nco_inc_sel.sv
module nco_inc_sel
    import sync_nco_pkg::*;
#(
    parameter int unsigned            ACC_W   = 32,
    parameter int unsigned            CORR_W  = 24,
    parameter logic [ACC_W-1:0]       NOM_INC = 32'h4000_0000
) (
    input  logic [1:0]               mode_i,
    input  logic signed [CORR_W-1:0] corr_i,
    input  logic [ACC_W-1:0]         hold_word_i,
    output logic [ACC_W-1:0]         inc_o
);

    localparam int unsigned EXT_W = ACC_W - CORR_W;

    logic [ACC_W-1:0] corr_ext;
    logic [ACC_W-1:0] track_inc;

    always_comb begin
        corr_ext  = {{EXT_W{corr_i[CORR_W-1]}}, corr_i};
        track_inc = NOM_INC + corr_ext;
        unique case (nco_mode_e'(mode_i))
            MODE_TRACK:    inc_o = track_inc;
            MODE_HOLD:     inc_o = hold_word_i;
            MODE_FREE:     inc_o = NOM_INC;
            MODE_FREE_ALT: inc_o = NOM_INC;
            default:       inc_o = NOM_INC;
        endcase
    end

endmodule

// File: rtl/nco_hold_avg.sv
module nco_hold_avg #(
    parameter int unsigned      ACC_W     = 32,
    parameter int unsigned      AVG_SHIFT = 6,
    parameter logic [ACC_W-1:0] NOM_INC   = 32'h4000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             update_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] hold_o
);

    typedef struct packed {
        logic [ACC_W-1:0] word;
    } hold_state_t;

    hold_state_t st_d, st_q;

    logic signed [ACC_W:0] diff;
    logic [ACC_W-1:0]      step;

    always_comb begin
        st_d = st_q;
        diff = $signed({1'b0, inc_i}) - $signed({1'b0, st_q.word});
        step = ACC_W'(diff >>> AVG_SHIFT);
        if (update_i) begin
            st_d.word = st_q.word + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= NOM_INC;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.word;

endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] phase_o,
    output logic             carry_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             cen;
    } acc_state_t;

    acc_state_t      st_d, st_q;
    logic [ACC_W:0]  sum;

    always_comb begin
        sum      = {1'b0, st_q.acc} + {1'b0, inc_i};
        st_d.acc = sum[ACC_W-1:0];
        st_d.cen = sum[ACC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.acc;
    assign carry_o = st_q.cen;

endmodule

// File: rtl/sync_nco.sv
module sync_nco
    import sync_nco_pkg::*;
#(
    parameter int unsigned      ACC_W     = 32,
    parameter int unsigned      CORR_W    = 24,
    parameter int unsigned      AVG_SHIFT = 6,
    parameter logic [ACC_W-1:0] NOM_INC   = 32'h4000_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic signed [CORR_W-1:0] corr_i,
    input  logic                     frame_stb_i,
    output logic                     clk_en_o,
    output logic [ACC_W-1:0]         phase_o
);

    logic [ACC_W-1:0] hold_word;
    logic [ACC_W-1:0] inc;
    logic             avg_update;

    assign avg_update = frame_stb_i & is_tracking(mode_i);

    nco_inc_sel #(
        .ACC_W  (ACC_W),
        .CORR_W (CORR_W),
        .NOM_INC(NOM_INC)
    ) u_sel (
        .mode_i     (mode_i),
        .corr_i     (corr_i),
        .hold_word_i(hold_word),
        .inc_o      (inc)
    );

    nco_hold_avg #(
        .ACC_W    (ACC_W),
        .AVG_SHIFT(AVG_SHIFT),
        .NOM_INC  (NOM_INC)
    ) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .update_i(avg_update),
        .inc_i   (inc),
        .hold_o  (hold_word)
    );

    nco_accum #(
        .ACC_W(ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc),
        .phase_o(phase_o),
        .carry_o(clk_en_o)
    );

endmodule

// File: rtl/sync_nco_chk.sv
module sync_nco_chk #(
    parameter int unsigned      ACC_W   = 32,
    parameter int unsigned      CORR_W  = 24,
    parameter logic [ACC_W-1:0] NOM_INC = 32'h4000_0000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               mode_i,
    input logic signed [CORR_W-1:0] corr_i,
    input logic                     clk_en_o,
    input logic [ACC_W-1:0]         phase_o,
    input logic [ACC_W-1:0]         hold_word
);

    logic [ACC_W-1:0] corr_wide;
    assign corr_wide = {{(ACC_W-CORR_W){corr_i[CORR_W-1]}}, corr_i};

    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (phase_o == '0 && clk_en_o == 1'b0);
        end
    end

    assert_track_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |=>
            (phase_o == ACC_W'($past(phase_o) + NOM_INC + $past(corr_wide))));

    assert_free_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |=> (phase_o == ACC_W'($past(phase_o) + NOM_INC)));

    assert_alt_free_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |=> (phase_o == ACC_W'($past(phase_o) + NOM_INC)));

    assert_hold_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |=> (phase_o == ACC_W'($past(phase_o) + $past(hold_word))));

    assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b00) |=> $stable(hold_word));

    assert_carry_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (clk_en_o == (phase_o < $past(phase_o))));

endmodule

bind sync_nco sync_nco_chk #(
    .ACC_W  (ACC_W),
    .CORR_W (CORR_W),
    .NOM_INC(NOM_INC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .corr_i   (corr_i),
    .clk_en_o (clk_en_o),
    .phase_o  (phase_o),
    .hold_word(hold_word)
);

// File: tb/sync_nco_test.sv
`timescale 1ns/1ps
module sync_nco_test;

    localparam int unsigned      ACC_W   = 32;
    localparam int unsigned      CORR_W  = 24;
    localparam logic [31:0]      NOM     = 32'h6A3D_70A4;
    localparam longint           MASK    = 64'h0000_0000_FFFF_FFFF;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [1:0]               mode = 2'b10;
    logic signed [CORR_W-1:0] corr = '0;
    logic                     stb = 1'b0;
    logic                     clk_en;
    logic [ACC_W-1:0]         phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m_acc;
    longint m_hold;
    longint m_cen;

    always #2 clk = ~clk;

    sync_nco #(
        .ACC_W    (ACC_W),
        .CORR_W   (CORR_W),
        .AVG_SHIFT(6),
        .NOM_INC  (NOM)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .corr_i     (corr),
        .frame_stb_i(stb),
        .clk_en_o   (clk_en),
        .phase_o    (phase)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, predict, and compare at the next falling edge.
    task automatic step(input string req, input logic [1:0] m, input int c, input bit s);
        longint inc;
        longint nxt;
        longint diff;
        mode = m;
        corr = c[CORR_W-1:0];
        stb  = s;
        if (m == 2'b00)      inc = (longint'(NOM) + longint'(c)) & MASK;
        else if (m == 2'b01) inc = m_hold;
        else                 inc = longint'(NOM);
        nxt = m_acc + inc;
        @(posedge clk);
        @(negedge clk);
        m_cen = (nxt >> 32) & 1;
        m_acc = nxt & MASK;
        if (s && m == 2'b00) begin
            diff   = inc - m_hold;
            m_hold = (m_hold + (diff >>> 6)) & MASK;
        end
        check(req, longint'(phase), m_acc);
        check("R8", longint'(clk_en), m_cen);
    endtask

    function automatic int pos_corr();
        return int'($urandom_range(0, 8388607));
    endfunction

    function automatic int neg_corr();
        return -int'($urandom_range(1, 8388608));
    endfunction

    initial begin
        m_acc  = 0;
        m_hold = longint'(NOM);
        m_cen  = 0;
        repeat (3) @(negedge clk);
        check("R1", longint'(phase), 0);
        check("R1", longint'(clk_en), 0);
        rst_n = 1'b1;

        // R2: tracking with positive corrections, no strobe
        for (int i = 0; i < 20; i++) step("R2", 2'b00, pos_corr(), 1'b0);
        // R1 holdover word reset value seen through holdover slope
        for (int i = 0; i < 5; i++) step("R1", 2'b01, pos_corr(), 1'b0);
        // R10: negative corrections, including the most negative value
        for (int i = 0; i < 20; i++) step("R10", 2'b00, neg_corr(), 1'b0);
        step("R10", 2'b00, -8388608, 1'b0);
        step("R10", 2'b00, 8388607, 1'b0);
        // R6: averaging while tracking with strobes
        for (int i = 0; i < 240; i++)
            step("R6", 2'b00, 4000000 + int'($urandom_range(0, 400000)), (i % 4) == 3);
        for (int i = 0; i < 20; i++) step("R5", 2'b01, neg_corr(), 1'b0);
        // R6 with negative pull
        for (int i = 0; i < 120; i++) step("R6", 2'b00, neg_corr(), (i % 3) == 0);
        for (int i = 0; i < 10; i++) step("R5", 2'b01, pos_corr(), 1'b1);
        // R3: free-run ignores correction and strobes
        for (int i = 0; i < 30; i++) step("R3", 2'b10, neg_corr(), i[0]);
        for (int i = 0; i < 10; i++) step("R7", 2'b01, pos_corr(), 1'b0);
        // R4: code 11 acts as free-run
        for (int i = 0; i < 30; i++) step("R4", 2'b11, pos_corr(), 1'b1);
        for (int i = 0; i < 10; i++) step("R7", 2'b01, 0, 1'b0);
        // R7: tracking without strobe keeps the word
        for (int i = 0; i < 20; i++) step("R7", 2'b00, 8388607, 1'b0);
        for (int i = 0; i < 10; i++) step("R7", 2'b01, 0, 1'b0);
        // R9: mode changes every cycle, phase continuous
        for (int i = 0; i < 60; i++)
            step("R9", 2'(i % 4), (i % 2) ? pos_corr() : neg_corr(), (i % 5) == 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule